// File: doc/BRIEF.md
# SmartCard Event Timer with Compare

This block is a free-running event counter for timing activity on a SmartCard link. All of its logic runs on a single system clock. The counter moves forward by one on each one-cycle pulse of a tick source. There are three tick sources: a baud tick, a receive tick and a transmit element-time tick. A 2-bit source select picks one of them.

The source select is also the counter's only enable and its only clear. The idle code holds the count at zero. Any other code lets the count run from the next selected tick onward.

A 16-bit compare value is loaded by software. When a tick moves the count onto that value, a sticky match flag is raised. The flag stays up until software pulses a clear strobe. An interrupt output follows the flag unless a mask input suppresses it.

Top module: `sc_event_timer`

## Requirements
- R1: After synchronous reset, the count is 0x0000 and both the flag and the interrupt are low.
- R2: With a non-idle source selected, each cycle in which the chosen tick is high raises the count by one at the next clock edge. A cycle without that tick leaves the count unchanged.
- R3: Source code 00 (idle) clears the count to zero at the next edge and holds it there. While the code is idle, ticks have no effect.
- R4: Code 01 selects the baud tick, code 10 the receive tick, and code 11 the transmit element-time tick. Pulses on the two unselected tick inputs do not change the count.
- R5: The count wraps from 0xFFFF to 0x0000 and keeps counting after a compare match.
- R6: The flag rises at the same edge at which a tick advances the count to the compare value. Reaching zero through the idle clear does not set it.
- R7: The flag is sticky until a one-cycle clear strobe. If a match and a clear occur in the same cycle, the match wins and the flag stays set.
- R8: The interrupt is high exactly when the flag is set and the mask input is low.
- R9: Changing the source between two non-idle codes keeps the current count. Counting continues from that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel_i | input | 2 | Tick source select; 00 idles and clears the count |
| baud_tick_i | input | 1 | Baud tick pulse |
| recv_tick_i | input | 1 | Receive tick pulse |
| xmit_tick_i | input | 1 | Transmit element-time tick pulse |
| cmp_val_i | input | 16 | Compare value |
| irq_mask_i | input | 1 | High suppresses the interrupt |
| flag_clr_i | input | 1 | Clear strobe for the match flag |
| count_o | output | 16 | Current count |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A compare match and the clear strobe can land in the same cycle. This is the one case where two functions compete for the flag. The bench provokes it in a directed step: it asserts the clear in exactly the cycle whose tick lands the count on the compare value, and it expects the flag to survive. The random phase asserts the clear often enough that further collisions occur by chance. Each of these collisions is judged against a bench model that gives the match priority.

// File: rtl/sct_pkg.sv
package sct_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'b00,
        SRC_BAUD = 2'b01,
        SRC_RECV = 2'b10,
        SRC_XMIT = 2'b11
    } src_e;

    typedef struct packed {
        logic baud;
        logic recv;
        logic xmit;
    } tick_t;

    function automatic logic pick_tick(input src_e src, input tick_t t);
        case (src)
            SRC_BAUD: return t.baud;
            SRC_RECV: return t.recv;
            SRC_XMIT: return t.xmit;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sct_tick_sel.sv
module sct_tick_sel
    import sct_pkg::*;
(
    input  src_e  src_i,
    input  tick_t ticks_i,
    output logic  run_o,
    output logic  adv_o
);

    always_comb begin
        run_o = (src_i != SRC_IDLE);
        adv_o = pick_tick(src_i, ticks_i);
    end

    always_comb begin
        AST_ADV_NEEDS_RUN: assert (!adv_o || run_o); // R3
    end

endmodule

// File: rtl/sct_counter.sv
module sct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] nxt_o
);

    logic [CNT_W-1:0] cnt_q;

    assign nxt_o = cnt_q + 1'b1;
    assign cnt_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= nxt_o;
        end
    end

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> cnt_o == '0); // R3
    AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (run_i && adv_i) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1)); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run_i && !adv_i) |=> $stable(cnt_o)); // R2

endmodule

// File: rtl/sct_match_flag.sv
module sct_match_flag #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] nxt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             clr_i,
    input  logic             mask_i,
    output logic             flag_o,
    output logic             irq_o
);

    logic hit;
    logic flag_q;

    assign hit    = adv_i && (nxt_i == cmp_i);
    assign flag_o = flag_q;
    assign irq_o  = flag_q && !mask_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o); // R7
    AST_MATCH_WINS: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_i) |=> flag_o); // R7
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (!hit && clr_i) |=> !flag_o); // R7

endmodule

// File: rtl/sc_event_timer.sv
module sc_event_timer
    import sct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       src_sel_i,
    input  logic             baud_tick_i,
    input  logic             recv_tick_i,
    input  logic             xmit_tick_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             irq_mask_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_o
);

    tick_t            ticks;
    src_e             src;
    logic             run;
    logic             adv;
    logic [CNT_W-1:0] nxt;

    assign src   = src_e'(src_sel_i);
    assign ticks = '{baud: baud_tick_i, recv: recv_tick_i, xmit: xmit_tick_i};

    sct_tick_sel i_tick_sel (
        .src_i   (src),
        .ticks_i (ticks),
        .run_o   (run),
        .adv_o   (adv)
    );

    sct_counter #(.CNT_W(CNT_W)) i_counter (
        .clk   (clk),
        .rst   (rst),
        .run_i (run),
        .adv_i (adv),
        .cnt_o (count_o),
        .nxt_o (nxt)
    );

    sct_match_flag #(.CNT_W(CNT_W)) i_match_flag (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (adv),
        .nxt_i  (nxt),
        .cmp_i  (cmp_val_i),
        .clr_i  (flag_clr_i),
        .mask_i (irq_mask_i),
        .flag_o (flag_o),
        .irq_o  (irq_o)
    );

    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
        (adv && nxt == cmp_val_i) |=> flag_o); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (flag_o && !irq_mask_i)); // R8

endmodule

// File: tb/test_sc_event_timer.sv
module test_sc_event_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  sel;
    logic        tb_baud, tb_recv, tb_xmit;
    logic [15:0] cmp;
    logic        mask, clr;
    logic [15:0] count;
    logic        flag, irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_cnt;
    logic        m_flag;

    always #5 clk = ~clk;

    sc_event_timer i_sc_event_timer (
        .clk(clk), .rst(rst), .src_sel_i(sel),
        .baud_tick_i(tb_baud), .recv_tick_i(tb_recv), .xmit_tick_i(tb_xmit),
        .cmp_val_i(cmp), .irq_mask_i(mask), .flag_clr_i(flag_clr_dummy()),
        .count_o(count), .flag_o(flag), .irq_o(irq)
    );

    function automatic logic flag_clr_dummy();
        return clr;
    endfunction

    function automatic logic sel_tick(input logic [1:0] s, input logic b,
                                      input logic r, input logic x);
        case (s)
            2'b01: return b;
            2'b10: return r;
            2'b11: return x;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at negedge, advance model, check after the edge
    task automatic cyc(input logic [1:0] s, input logic b, input logic r, input logic x,
                       input logic [15:0] c, input logic m, input logic cl, input bit check);
        logic adv;
        logic [15:0] nx;
        @(negedge clk);
        sel = s; tb_baud = b; tb_recv = r; tb_xmit = x; cmp = c; mask = m; clr = cl;
        adv = sel_tick(s, b, r, x);
        nx  = m_cnt + 16'd1;
        if (s == 2'b00) m_cnt = '0;
        else if (adv) m_cnt = nx;
        if (s != 2'b00 && adv && nx == c) m_flag = 1'b1;
        else if (cl) m_flag = 1'b0;
        @(posedge clk); #1;
        if (check) begin
            chk("R2 count", count, m_cnt);
            chk("R7 flag", flag, m_flag);
            chk("R8 irq", irq, m_flag & ~m);
        end
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; sel = 2'b00; tb_baud = 0; tb_recv = 0; tb_xmit = 0;
        cmp = 16'h0005; mask = 0; clr = 0;
        m_cnt = '0; m_flag = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 count", count, 16'h0);
        chk("R1 flag", flag, 1'b0);
        chk("R1 irq", irq, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R3: idle ignores ticks
        for (int i = 0; i < 4; i++) cyc(2'b00, 1, 1, 1, 16'h0001, 0, 0, 1);
        chk("R3 idle", count, 16'h0);

        // R4: each code follows only its own tick
        cyc(2'b01, 0, 1, 1, 16'h0100, 0, 0, 1);
        chk("R4 baud ignores others", count, 16'h0);
        cyc(2'b01, 1, 0, 0, 16'h0100, 0, 0, 1);
        chk("R4 baud counts", count, 16'h1);
        // R9: switch source keeps count
        cyc(2'b10, 1, 0, 1, 16'h0100, 0, 0, 1);
        chk("R9 keep on switch", count, 16'h1);
        cyc(2'b10, 0, 1, 0, 16'h0100, 0, 0, 1);
        chk("R4 recv counts", count, 16'h2);
        cyc(2'b11, 0, 0, 1, 16'h0100, 0, 0, 1);
        chk("R4 xmit counts", count, 16'h3);

        // R6: match sets flag at advancing edge, masked then unmasked
        cyc(2'b11, 0, 0, 1, 16'h0004, 1, 0, 1);
        chk("R6 flag", flag, 1'b1);
        chk("R8 masked irq", irq, 1'b0);
        cyc(2'b11, 0, 0, 0, 16'h0004, 0, 0, 1);
        chk("R8 irq", irq, 1'b1);
        // R7: clear drops flag
        cyc(2'b11, 0, 0, 0, 16'h0004, 0, 1, 1);
        chk("R7 clear", flag, 1'b0);
        // R7: match and clear same cycle, match wins
        cyc(2'b11, 0, 0, 1, 16'h0005, 0, 1, 1);
        chk("R7 match wins", flag, 1'b1);
        cyc(2'b11, 0, 0, 0, 16'h0005, 0, 1, 1);

        // R6: idle clear onto compare value 0 does not set
        cyc(2'b00, 0, 0, 0, 16'h0000, 0, 0, 1);
        chk("R6 idle no set", flag, 1'b0);
        chk("R3 cleared", count, 16'h0);

        // R5: run to 0xFFFF with match, then wrap and continue
        for (int i = 0; i < 65535; i++) cyc(2'b01, 1, 0, 0, 16'hFFFF, 0, 0, 0);
        chk("R5 top", count, 16'hFFFF);
        chk("R6 match at top", flag, 1'b1);
        cyc(2'b01, 1, 0, 0, 16'hFFFF, 0, 0, 1);
        chk("R5 wrap", count, 16'h0);
        cyc(2'b01, 1, 0, 0, 16'hFFFF, 0, 0, 1);
        chk("R5 continue", count, 16'h1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  s;
            logic [15:0] c;
            s = (($urandom % 16) == 0) ? 2'b00 : 2'($urandom % 4);
            c = 16'(($urandom % 24));
            cyc(s, 1'($urandom), 1'($urandom), 1'($urandom), c,
                1'($urandom), (($urandom % 4) == 0), 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule